// File: doc/BRIEF.md
# Supervisor-View CSR Register File

This block holds the machine-level and supervisor-level control and status registers of one 64-bit RISC-V hart. Software reaches them through a single CSR port: a 12-bit CSR number, 64-bit write data and a write strobe. Read data is combinational for the number currently on the port. A write is committed on the next rising clock edge.

The supervisor status, interrupt-enable and interrupt-pending registers have no storage of their own. Each one is a fixed-mask window onto the matching machine register. The floating-point state field is stored separately and merged into both status views on every read. A 64-bit counter serves cycle, mcycle and minstret.

The pending register is the OR of a live hardware vector and a software-pending word. Side outputs carry the composed machine status, the enable and delegation words and the translation root. A registered one-cycle pulse tells the address translator to drop its cached entries.

Top module: `csr_supv_file`

## Requirements
- R1: After synchronous reset, the registers read as follows. Machine status (0x300) reads 0x0000_000A_0000_1800, which is UXL=2 at bits 33:32, SXL=2 at bits 35:34 and MPP=3 at bits 12:11. Supervisor status (0x100) reads 0x0000_0002_0000_0000. mhartid (0xF14) reads the HART_ID parameter. All other stored registers read 0, and the flush output is low.
- R2: misa (0x301) always reads 0x8000_0000_0014_112D. This value is the 64-bit base in bits 63:62 plus the letters S, U, I, M, A, F, D and C, each at bit (letter minus 'A'). Writes to misa are ignored.
- R3: mideleg (0x303) stores only the written bits under mask 0x222. All its other bits read 0.
- R4: Reading sie (0x104) returns mie AND mideleg. Writing sie replaces only the mie (0x304) bits under 0x222 and leaves the rest of mie unchanged.
- R5: Reading mip (0x344) returns the live pending input OR the software-pending word. Writing mip loads the whole software-pending word. Writing sip (0x144) replaces only the software-pending bits under 0x222. Reading sip returns the pending value AND mideleg.
- R6: Reading sstatus returns mstatus AND 0x8000_0003_000D_E162. Writing sstatus changes only those bits of mstatus.
- R7: The FS field (bits 14:13) is loaded by every write to mstatus or sstatus and is inserted into both views on read. Bit 63 reads as 1 exactly when FS is 3.
- R8: A write to mstatus leaves VS (bits 10:9), UXL and SXL unchanged.
- R9: cycle (0xC00), mcycle (0xB00) and minstret (0xB02) all read one counter that increases by 1 every clock. Only a write to mcycle loads it. A write to cycle raises the reject output in that same cycle and does not change the counter. A write to minstret is ignored.
- R10: A write to satp (0x180) stores the full value. The flush output is high for exactly the one cycle after the write edge.
- R11: Reading an unimplemented CSR number returns 0, and writing one has no effect.
- R12: Writes take effect at the next rising edge. A read of the same register in the cycle of the write returns the old value.
- R13: The trap vector, scratch, exception PC, cause, trap value and delegation registers of both levels each store a full 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR number to read or write |
| csr_wdata | input | 64 | Write data |
| csr_we | input | 1 | Write strobe, committed at the next rising edge |
| csr_rdata | output | 64 | Combinational read data for csr_addr |
| csr_wr_reject | output | 1 | High while a write targets the read-only cycle counter |
| irq_pend_i | input | 64 | Live hardware interrupt-pending vector |
| mstatus_o | output | 64 | Composed machine status, with FS and SD included |
| mie_o | output | 64 | Machine interrupt-enable word |
| mideleg_o | output | 64 | Interrupt delegation word |
| satp_o | output | 64 | Translation root register |
| tlb_flush_o | output | 1 | One-cycle translation-cache flush pulse |

## Verification
Read data and the reject flag are combinational, so the bench samples them 1 time unit after driving the port, in the same cycle. A stored value is due one rising edge after its write strobe. The bench therefore drives inputs at the falling edge, lets one rising edge pass, and reads back at the next falling edge.

The flush pulse must be high in the single cycle after the satp write edge and low one edge later. Counter checks read the counter at falling edges a known number of edges apart and compare the difference.

// File: rtl/csrf_pkg.sv
package csrf_pkg;

    localparam int XLEN = 64;
    typedef logic [XLEN-1:0] xword_t;
    typedef logic [11:0]     csr_num_t;

    // CSR numbers decoded by the neighbouring pipeline
    localparam csr_num_t N_SSTATUS  = 12'h100;
    localparam csr_num_t N_SEDELEG  = 12'h102;
    localparam csr_num_t N_SIDELEG  = 12'h103;
    localparam csr_num_t N_SIE      = 12'h104;
    localparam csr_num_t N_STVEC    = 12'h105;
    localparam csr_num_t N_SSCRATCH = 12'h140;
    localparam csr_num_t N_SEPC     = 12'h141;
    localparam csr_num_t N_SCAUSE   = 12'h142;
    localparam csr_num_t N_STVAL    = 12'h143;
    localparam csr_num_t N_SIP      = 12'h144;
    localparam csr_num_t N_SATP     = 12'h180;
    localparam csr_num_t N_MSTATUS  = 12'h300;
    localparam csr_num_t N_MISA     = 12'h301;
    localparam csr_num_t N_MEDELEG  = 12'h302;
    localparam csr_num_t N_MIDELEG  = 12'h303;
    localparam csr_num_t N_MIE      = 12'h304;
    localparam csr_num_t N_MTVEC    = 12'h305;
    localparam csr_num_t N_MSCRATCH = 12'h340;
    localparam csr_num_t N_MEPC     = 12'h341;
    localparam csr_num_t N_MCAUSE   = 12'h342;
    localparam csr_num_t N_MTVAL    = 12'h343;
    localparam csr_num_t N_MIP      = 12'h344;
    localparam csr_num_t N_MCYCLE   = 12'h b00;
    localparam csr_num_t N_MINSTRET = 12'hb02;
    localparam csr_num_t N_CYCLE    = 12'hc00;
    localparam csr_num_t N_MHARTID  = 12'hf14;

    // Supervisor windows
    localparam xword_t SUP_IRQ_MASK   = 64'h0000_0000_0000_0222;
    localparam xword_t SUP_STAT_VIEW  = 64'h8000_0003_000D_E162;
    // Status bits held in the stored word (FS and SD are kept out of it)
    localparam xword_t SUP_STAT_STORE = 64'h0000_0003_000D_8162;
    localparam xword_t MACH_STAT_WR   = 64'h0000_0030_007E_19EA;
    localparam xword_t STAT_RESET     = 64'h0000_000A_0000_1800;
    localparam int     FS_LO          = 13;
    localparam int     SD_POS         = 63;

    // Plain full-width registers
    localparam int PLAIN_N   = 14;
    localparam int PLAIN_IW  = $clog2(PLAIN_N);
    localparam int HART_SLOT = 6;

    typedef struct packed {
        logic     we;
        csr_num_t addr;
        xword_t   wdata;
    } csr_req_t;

    // Extension letters packed as bytes, one per slot
    localparam logic [63:0] ISA_LETTERS = "SUIMAFDC";

    function automatic xword_t isa_word();
        xword_t w;
        w = 64'd2 << 62;
        for (int i = 0; i < 8; i++) begin
            w[ISA_LETTERS[i*8 +: 8] - 8'h41] = 1'b1;
        end
        return w;
    endfunction

    localparam xword_t ISA_VALUE = isa_word();

    function automatic int plain_slot(csr_num_t a);
        case (a)
            N_MTVEC:    return 0;
            N_MSCRATCH: return 1;
            N_MEPC:     return 2;
            N_MCAUSE:   return 3;
            N_MTVAL:    return 4;
            N_MEDELEG:  return 5;
            N_MHARTID:  return HART_SLOT;
            N_STVEC:    return 7;
            N_SSCRATCH: return 8;
            N_SEPC:     return 9;
            N_SCAUSE:   return 10;
            N_STVAL:    return 11;
            N_SEDELEG:  return 12;
            N_SIDELEG:  return 13;
            default:    return -1;
        endcase
    endfunction

endpackage

// File: rtl/csrf_status_unit.sv
module csrf_status_unit
    import csrf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  csr_req_t req,
    output xword_t   mach_view,
    output xword_t   sup_view
);
    xword_t     stored;
    logic [1:0] fs;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= STAT_RESET;
            fs     <= 2'b00;
        end else if (req.we && req.addr == N_MSTATUS) begin
            stored <= (req.wdata & MACH_STAT_WR) | (stored & ~MACH_STAT_WR);
            fs     <= req.wdata[FS_LO +: 2];
        end else if (req.we && req.addr == N_SSTATUS) begin
            stored <= (req.wdata & SUP_STAT_STORE) | (stored & ~SUP_STAT_STORE);
            fs     <= req.wdata[FS_LO +: 2];
        end
    end

    always_comb begin
        mach_view              = stored;
        mach_view[FS_LO +: 2]  = fs;
        mach_view[SD_POS]      = (fs == 2'b11);
        sup_view               = mach_view & SUP_STAT_VIEW;
    end

endmodule

// File: rtl/csrf_cycle_ctr.sv
module csrf_cycle_ctr
    import csrf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  csr_req_t     req,
    output logic [W-1:0] count,
    output logic         reject
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (req.we && req.addr == N_MCYCLE) begin
            count <= req.wdata[W-1:0];
        end else begin
            count <= count + 1'b1;
        end
    end

    assign reject = req.we && (req.addr == N_CYCLE);

endmodule

// File: rtl/csrf_plain_bank.sv
module csrf_plain_bank
    import csrf_pkg::*;
#(
    parameter xword_t HART_ID = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  csr_req_t req,
    output logic     hit,
    output xword_t   rdata
);
    xword_t              regs [PLAIN_N];
    int                  slot;
    logic [PLAIN_IW-1:0] idx;

    assign slot = plain_slot(req.addr);
    assign hit  = (slot >= 0);
    assign idx  = PLAIN_IW'(slot);

    for (genvar g = 0; g < PLAIN_N; g++) begin : g_slot
        localparam xword_t RST_VAL = (g == HART_SLOT) ? HART_ID : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (req.we && slot == g) begin
                regs[g] <= req.wdata;
            end
        end
    end

    assign rdata = hit ? regs[idx] : '0;

endmodule

// File: rtl/csr_supv_file.sv
module csr_supv_file
    import csrf_pkg::*;
#(
    parameter logic [63:0] HART_ID = 64'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] csr_addr,
    input  logic [63:0] csr_wdata,
    input  logic        csr_we,
    output logic [63:0] csr_rdata,
    output logic        csr_wr_reject,
    input  logic [63:0] irq_pend_i,
    output logic [63:0] mstatus_o,
    output logic [63:0] mie_o,
    output logic [63:0] mideleg_o,
    output logic [63:0] satp_o,
    output logic        tlb_flush_o
);
    csr_req_t req;
    assign req = '{we: csr_we, addr: csr_addr, wdata: csr_wdata};

    xword_t mach_stat, sup_stat, cyc, plain_q;
    logic   plain_hit;

    csrf_status_unit u_status (
        .clk(clk), .rst(rst), .req(req),
        .mach_view(mach_stat), .sup_view(sup_stat)
    );

    csrf_cycle_ctr #(.W(XLEN)) u_cycle (
        .clk(clk), .rst(rst), .req(req),
        .count(cyc), .reject(csr_wr_reject)
    );

    csrf_plain_bank #(.HART_ID(HART_ID)) u_plain (
        .clk(clk), .rst(rst), .req(req),
        .hit(plain_hit), .rdata(plain_q)
    );

    // Interrupt enable, delegation, software pending, translation root
    xword_t mie_q, mideleg_q, soft_pend_q, satp_q, pend;
    logic   flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mie_q       <= '0;
            mideleg_q   <= '0;
            soft_pend_q <= '0;
            satp_q      <= '0;
            flush_q     <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (csr_we) begin
                case (csr_addr)
                    N_MIE:     mie_q       <= csr_wdata;
                    N_SIE:     mie_q       <= (csr_wdata & SUP_IRQ_MASK) | (mie_q & ~SUP_IRQ_MASK);
                    N_MIDELEG: mideleg_q   <= csr_wdata & SUP_IRQ_MASK;
                    N_MIP:     soft_pend_q <= csr_wdata;
                    N_SIP:     soft_pend_q <= (csr_wdata & SUP_IRQ_MASK) | (soft_pend_q & ~SUP_IRQ_MASK);
                    N_SATP: begin
                        satp_q  <= csr_wdata;
                        flush_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pend = irq_pend_i | soft_pend_q;

    always_comb begin
        case (csr_addr)
            N_MSTATUS:                     csr_rdata = mach_stat;
            N_SSTATUS:                     csr_rdata = sup_stat;
            N_MISA:                        csr_rdata = ISA_VALUE;
            N_MIE:                         csr_rdata = mie_q;
            N_SIE:                         csr_rdata = mie_q & mideleg_q;
            N_MIDELEG:                     csr_rdata = mideleg_q;
            N_MIP:                         csr_rdata = pend;
            N_SIP:                         csr_rdata = pend & mideleg_q;
            N_SATP:                        csr_rdata = satp_q;
            N_CYCLE, N_MCYCLE, N_MINSTRET: csr_rdata = cyc;
            default:                       csr_rdata = plain_hit ? plain_q : '0;
        endcase
    end

    assign mstatus_o   = mach_stat;
    assign mie_o       = mie_q;
    assign mideleg_o   = mideleg_q;
    assign satp_o      = satp_q;
    assign tlb_flush_o = flush_q;

endmodule

// File: rtl/csr_supv_file_chk.sv
module csr_supv_file_chk
    import csrf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [11:0] csr_addr,
    input logic [63:0] csr_wdata,
    input logic        csr_we,
    input logic [63:0] csr_rdata,
    input logic [63:0] mstatus_o,
    input logic [63:0] mie_o,
    input logic [63:0] mideleg_o,
    input logic [63:0] satp_o,
    input logic        tlb_flush_o
);
    a_r10_flush_after_write: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == N_SATP) |=> (tlb_flush_o && satp_o == $past(csr_wdata)));

    a_r10_flush_drops: assert property (@(posedge clk) disable iff (rst)
        !(csr_we && csr_addr == N_SATP) |=> !tlb_flush_o);

    a_r3_deleg_masked: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == N_MIDELEG) |=> (mideleg_o == ($past(csr_wdata) & SUP_IRQ_MASK)));

    a_r4_sie_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == N_SIE) |=> ((mie_o & ~SUP_IRQ_MASK) == ($past(mie_o) & ~SUP_IRQ_MASK)));

    a_r8_fixed_fields: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == N_MSTATUS) |=> (mstatus_o[35:32] == $past(mstatus_o[35:32])
                                               && mstatus_o[10:9] == $past(mstatus_o[10:9])));

    a_r7_sd_tracks_fs: assert property (@(posedge clk) disable iff (rst)
        mstatus_o[63] == (mstatus_o[14:13] == 2'b11));

    a_r2_isa_constant: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == N_MISA) |-> (csr_rdata == 64'h8000_0000_0014_112D));

    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == 12'h7C0) |-> (csr_rdata == 64'd0));
endmodule

bind csr_supv_file csr_supv_file_chk u_chk (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .mstatus_o(mstatus_o),
    .mie_o(mie_o), .mideleg_o(mideleg_o), .satp_o(satp_o),
    .tlb_flush_o(tlb_flush_o)
);

// File: tb/csr_supv_file_tb.sv
module csr_supv_file_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] HART       = 64'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_rdata;
    logic        csr_wr_reject;
    logic [63:0] irq_pend_i = '0;
    logic [63:0] mstatus_o, mie_o, mideleg_o, satp_o;
    logic        tlb_flush_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_supv_file #(.HART_ID(HART)) dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata), .csr_wr_reject(csr_wr_reject),
        .irq_pend_i(irq_pend_i), .mstatus_o(mstatus_o), .mie_o(mie_o),
        .mideleg_o(mideleg_o), .satp_o(satp_o), .tlb_flush_o(tlb_flush_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [11:0] wa;
        logic [63:0] wd;
        logic [11:0] ra;
        logic [63:0] ex;
    } vec_t;

    // Each entry: write wa<=wd, then read ra and expect ex (sequence-dependent)
    localparam vec_t TBL [14] = '{
        '{8'd13, 12'h340, 64'h0123_4567_89AB_CDEF, 12'h340, 64'h0123_4567_89AB_CDEF}, // R13
        '{8'd3,  12'h303, 64'hFFFF_FFFF_FFFF_FFFF, 12'h303, 64'h0000_0000_0000_0222}, // R3
        '{8'd4,  12'h304, 64'h0000_0000_0000_0FFF, 12'h104, 64'h0000_0000_0000_0222}, // R4
        '{8'd4,  12'h104, 64'h0000_0000_0000_0000, 12'h304, 64'h0000_0000_0000_0DDD}, // R4
        '{8'd2,  12'h301, 64'h0000_0000_0000_0000, 12'h301, 64'h8000_0000_0014_112D}, // R2
        '{8'd11, 12'h7C0, 64'h0000_0000_0000_FFFF, 12'h7C0, 64'h0000_0000_0000_0000}, // R11
        '{8'd5,  12'h344, 64'h0000_0000_0000_00AA, 12'h344, 64'h0000_0000_0000_00AA}, // R5
        '{8'd5,  12'h144, 64'h0000_0000_0000_0000, 12'h344, 64'h0000_0000_0000_0088}, // R5
        '{8'd5,  12'h144, 64'h0000_0000_0000_FFFF, 12'h144, 64'h0000_0000_0000_0222}, // R5
        '{8'd13, 12'h105, 64'h0000_0000_8000_1000, 12'h105, 64'h0000_0000_8000_1000}, // R13
        '{8'd8,  12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 12'h300, 64'h8000_003A_007E_79EA}, // R8 R7
        '{8'd6,  12'h100, 64'h0000_0000_0000_0000, 12'h300, 64'h0000_0038_0072_1888}, // R6
        '{8'd6,  12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 12'h100, 64'h8000_0003_000D_E162}, // R6 R7
        '{8'd10, 12'h180, 64'h8000_0000_0008_0000, 12'h180, 64'h8000_0000_0008_0000}  // R10
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_we    = 1'b1;
        @(posedge clk);
        #1;
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        @(negedge clk);
        csr_we   = 1'b0;
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    initial begin
        logic [63:0] v, c1, c2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(12'h300, v); check("R1 mstatus reset", v, 64'h0000_000A_0000_1800);
        rd(12'h100, v); check("R1 sstatus reset", v, 64'h0000_0002_0000_0000);
        rd(12'hF14, v); check("R1 hart id", v, HART);
        rd(12'h341, v); check("R1 mepc reset", v, 64'd0);
        rd(12'h304, v); check("R1 mie reset", v, 64'd0);
        check("R1 flush low", {63'd0, tlb_flush_o}, 64'd0);

        // vector table
        for (int i = 0; i < 14; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            rd(TBL[i].ra, v);
            check($sformatf("R%0d table entry %0d", TBL[i].req, i), v, TBL[i].ex);
        end
        check("R4 mie side output", mie_o, 64'h0DDD);
        check("R3 mideleg side output", mideleg_o, 64'h0222);

        // R5 live pending input merged with software bits
        irq_pend_i = 64'h800;
        rd(12'h344, v); check("R5 mip with live input", v, 64'hAAA);
        rd(12'h144, v); check("R5 sip masked by deleg", v, 64'h222);
        irq_pend_i = 64'h0;

        // R10 flush pulse timing
        wr(12'h180, 64'h1234);
        check("R10 flush after write", {63'd0, tlb_flush_o}, 64'd1);
        check("R10 satp side output", satp_o, 64'h1234);
        @(posedge clk); #1;
        check("R10 flush one cycle", {63'd0, tlb_flush_o}, 64'd0);

        // R9 counter
        rd(12'hB00, c1);
        repeat (4) @(negedge clk);
        rd(12'hB00, c2);
        check("R9 counter step", c2 - c1, 64'd5);
        @(negedge clk);
        csr_addr = 12'hC00; #1; c1 = csr_rdata;
        csr_addr = 12'hB02; #1; c2 = csr_rdata;
        check("R9 shared counter", c2, c1);
        wr(12'hB00, 64'd1000);
        rd(12'hC00, v); check("R9 mcycle load", v, 64'd1000);
        @(negedge clk);
        csr_addr = 12'hC00; csr_wdata = 64'd5; csr_we = 1'b1;
        #1;
        c1 = csr_rdata;
        check("R9 cycle write rejected", {63'd0, csr_wr_reject}, 64'd1);
        @(posedge clk); #1; csr_we = 1'b0;
        rd(12'hC00, v); check("R9 cycle write no effect", v, c1 + 64'd1);
        rd(12'hB02, c1);
        wr(12'hB02, 64'd0);
        rd(12'hB02, v); check("R9 minstret write ignored", v, c1 + 64'd2);

        // R12 same-cycle read returns old value
        wr(12'h140, 64'h5555);
        @(negedge clk);
        csr_addr = 12'h140; csr_wdata = 64'hAAAA; csr_we = 1'b1;
        #1;
        check("R12 old value during write", csr_rdata, 64'h5555);
        @(posedge clk); #1; csr_we = 1'b0;
        check("R12 new value after edge", csr_rdata, 64'hAAAA);

        // R11 write to a hole leaves neighbours intact
        wr(12'h7C1, 64'hFFFF);
        rd(12'h340, v); check("R11 hole write no effect", v, 64'h0123_4567_89AB_CDEF);
        rd(12'h7C1, v); check("R11 hole reads zero", v, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule